// File: doc/BRIEF.md
# Dual-Lane SIMD Multiply-Accumulate Unit

This block is a two-lane SIMD multiplier with an attached 64-bit accumulator. Each 64-bit operand is split into two 32-bit lanes. The lanes are multiplied in parallel and on their own. A halfword product takes one 16-bit half of each lane. A word product keeps either the upper or the lower 32 bits of a lane's 32x32 product. The full-word product returns the whole 64-bit product of the low lane.

The arithmetic can be signed or unsigned, and overflow can either clamp (saturate) or wrap (modulo). Signed products can also be read as fractions. A fractional product is the signed product doubled, so the redundant sign bit drops out and a zero fills the bottom bit.

The product can go straight to the result or be combined with the registered accumulator. It can be copied into the accumulator, or added to or subtracted from it. The add and subtract can run as one 64-bit operation or as two separate 32-bit operations. The multiply path is combinational. The accumulator changes on a clock edge only when the valid strobe is high and an accumulator mode is selected.

Top module: `simd_mac`

## Requirements
- R1: Lane 0 is bits [31:0] and lane 1 is bits [63:32] of each operand and of the result. In the halfword and word-high/low modes, a lane's result and overflow flag depend only on that lane's operand bits.
- R2: `prodMode` 0 (halfword low) multiplies bits [15:0] of each lane. `prodMode` 1 (halfword high) multiplies bits [31:16] of each lane. Either gives a 32-bit product per lane, signed when `isSigned`=1 and unsigned otherwise.
- R3: `prodMode` 2 puts the upper 32 bits of each lane's 64-bit product into that lane. `prodMode` 3 puts the lower 32 bits there.
- R4: `prodMode` 4 returns the full 64-bit product of opA[31:0] and opB[31:0]. In this mode `ovf[1]` is always 0. Codes 5 to 7 behave as code 0.
- R5: When `isSigned`=1 and `isFrac`=1, the product is the signed product shifted left by one with bit 0 at zero. `isFrac` has no effect when `isSigned`=0.
- R6: A fractional product of two most-negative operands (0x8000 for halfwords, 0x80000000 for words) is handled by `isSat`. With `isSat`=1 it gives 0x7FFFFFFF in the lane, or 0x7FFFFFFFFFFFFFFF in mode 4, and sets that lane's `ovf` bit. With `isSat`=0 it gives 0x80000000 in the lane, or 0x8000000000000000 in mode 4, with the flag clear.
- R7: In mode 3 with `isSat`=1, a product that does not fit the lane is clamped and sets the lane's `ovf` bit. A signed product clamps to 0x7FFFFFFF or 0x80000000. An unsigned product clamps to 0xFFFFFFFF.
- R8: With `isSat`=0 both `ovf` bits are 0 and the results wrap.
- R9: Mode 3 ignores `isFrac` and always forms the integer product. The result is then the same as with `isFrac`=0.
- R10: `accMode` sets what the result holds:
  - 0 (none) and 1 (write): the product.
  - 2: accumulator plus product.
  - 3: accumulator minus product.
  - 4: per 32-bit word, accumulator plus product, with no carry between words.
  - 5: per 32-bit word, accumulator minus product.
  - 6 and 7: the same as 0.
- R11: The accumulator resets to 0. On a rising clock edge it loads `result` only if `valid`=1 and `accMode` is 1 to 5. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Lets the accumulator update on this edge |
| opA | input | 64 | First operand, two 32-bit lanes |
| opB | input | 64 | Second operand, two 32-bit lanes |
| prodMode | input | 3 | Product selection (R2 to R4) |
| isSigned | input | 1 | Signed operands |
| isSat | input | 1 | Saturate (1) or wrap (0) |
| isFrac | input | 1 | Fractional alignment for signed operands |
| accMode | input | 3 | Accumulator combination (R10) |
| result | output | 64 | Combinational result |
| acc | output | 64 | Registered accumulator |
| ovf | output | 2 | Per-lane overflow flags, bit 0 for lane 0 |

## Verification
The assertions are checked on every cycle and cover four behaviours:
- The overflow flags stay clear in wrap mode.
- The upper flag stays clear in full-word mode.
- A saturated signed low-word lane holds one of the two clamp values.
- The accumulator either holds its value or takes the previous cycle's result, as the decoded load strobe dictates.

The numeric correctness of every product mode cannot be shown by a per-cycle property. This includes fractional alignment, the most-negative-squared corner, independence of the lanes and carry isolation in the per-word accumulate. Only the bench can show these, by comparing against its own arithmetic model over directed and random operands.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
  localparam int LANE_W = 32;
  localparam int HALF_W = LANE_W / 2;
  localparam int DATA_W = 2 * LANE_W;
  localparam int NUM_LANES = DATA_W / LANE_W;

  localparam logic [2:0] PM_HALF_LO = 3'd0;
  localparam logic [2:0] PM_HALF_HI = 3'd1;
  localparam logic [2:0] PM_WORD_HI = 3'd2;
  localparam logic [2:0] PM_WORD_LO = 3'd3;
  localparam logic [2:0] PM_FULL    = 3'd4;

  localparam logic [2:0] AM_NONE    = 3'd0;
  localparam logic [2:0] AM_WRITE   = 3'd1;
  localparam logic [2:0] AM_ADD     = 3'd2;
  localparam logic [2:0] AM_SUB     = 3'd3;
  localparam logic [2:0] AM_ADD_WRD = 3'd4;
  localparam logic [2:0] AM_SUB_WRD = 3'd5;

  typedef struct packed {
    logic load;
    logic doAdd;
    logic doSub;
    logic perWord;
  } accCtl_t;
endpackage

// File: rtl/simd_mac_ctrl.sv
module simd_mac_ctrl
  import simd_mac_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] accMode,
  output accCtl_t    ctl
);
  always_comb begin
    ctl = '0;
    unique case (accMode)
      AM_WRITE:   ctl.load = valid;
      AM_ADD:     begin ctl.load = valid; ctl.doAdd = 1'b1; end
      AM_SUB:     begin ctl.load = valid; ctl.doSub = 1'b1; end
      AM_ADD_WRD: begin ctl.load = valid; ctl.doAdd = 1'b1; ctl.perWord = 1'b1; end
      AM_SUB_WRD: begin ctl.load = valid; ctl.doSub = 1'b1; ctl.perWord = 1'b1; end
      default:    ctl = '0;
    endcase
  end
endmodule

// File: rtl/simd_mac_lane.sv
module simd_mac_lane
  import simd_mac_pkg::*;
(
  input  logic [LANE_W-1:0]   a,
  input  logic [LANE_W-1:0]   b,
  input  logic [2:0]          prodMode,
  input  logic                isSigned,
  input  logic                isSat,
  input  logic                isFrac,
  output logic [LANE_W-1:0]   laneRes,
  output logic                laneOv,
  output logic [DATA_W-1:0]   fullProd,
  output logic                fracMin
);
  localparam logic [HALF_W-1:0] HALF_MIN = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] WORD_MIN = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] WORD_MAX = {1'b0, {(LANE_W-1){1'b1}}};

  logic isHalf, isWordLo, fracEff, intOvf, ovEvent;
  logic [HALF_W-1:0] ah, bh;
  logic signed [DATA_W-1:0] extA, extB, prod;
  logic [LANE_W-1:0] rawVal, clampVal;

  assign isWordLo = (prodMode == PM_WORD_LO);
  assign isHalf   = !(prodMode == PM_WORD_HI || isWordLo || prodMode == PM_FULL);
  assign ah = (prodMode == PM_HALF_HI) ? a[LANE_W-1:HALF_W] : a[HALF_W-1:0];
  assign bh = (prodMode == PM_HALF_HI) ? b[LANE_W-1:HALF_W] : b[HALF_W-1:0];

  assign extA = isHalf ? {{(DATA_W-HALF_W){isSigned & ah[HALF_W-1]}}, ah}
                       : {{(DATA_W-LANE_W){isSigned & a[LANE_W-1]}}, a};
  assign extB = isHalf ? {{(DATA_W-HALF_W){isSigned & bh[HALF_W-1]}}, bh}
                       : {{(DATA_W-LANE_W){isSigned & b[LANE_W-1]}}, b};
  assign prod = extA * extB;

  assign fracEff  = isFrac & isSigned & !isWordLo;
  assign fullProd = fracEff ? {prod[DATA_W-2:0], 1'b0} : prod;
  assign fracMin  = fracEff & (isHalf ? (ah == HALF_MIN && bh == HALF_MIN)
                                      : (a == WORD_MIN && b == WORD_MIN));

  assign intOvf = isWordLo & (isSigned
                  ? (fullProd[DATA_W-1:LANE_W-1] != {(LANE_W+1){fullProd[LANE_W-1]}})
                  : (|fullProd[DATA_W-1:LANE_W]));
  assign ovEvent = fracMin | intOvf;

  always_comb begin
    rawVal = (prodMode == PM_WORD_HI) ? fullProd[DATA_W-1:LANE_W] : fullProd[LANE_W-1:0];
    if (fracMin)       clampVal = WORD_MAX;
    else if (isSigned) clampVal = fullProd[DATA_W-1] ? WORD_MIN : WORD_MAX;
    else               clampVal = '1;
  end

  assign laneOv  = isSat & ovEvent;
  assign laneRes = laneOv ? clampVal : rawVal;
endmodule

// File: rtl/simd_mac_dp.sv
module simd_mac_dp
  import simd_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        prodMode,
  input  logic              isSigned,
  input  logic              isSat,
  input  logic              isFrac,
  input  accCtl_t           ctl,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] acc,
  output logic [1:0]        ovf
);
  localparam logic [DATA_W-1:0] FULL_MAX = {1'b0, {(DATA_W-1){1'b1}}};

  logic [LANE_W-1:0] laneRes [NUM_LANES];
  logic [DATA_W-1:0] laneFull [NUM_LANES];
  logic [NUM_LANES-1:0] laneOv, laneFracMin;
  logic [DATA_W-1:0] product, operand, sum;
  logic fullMode;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    simd_mac_lane u_lane (
      .a        (opA[g*LANE_W +: LANE_W]),
      .b        (opB[g*LANE_W +: LANE_W]),
      .prodMode (prodMode),
      .isSigned (isSigned),
      .isSat    (isSat),
      .isFrac   (isFrac),
      .laneRes  (laneRes[g]),
      .laneOv   (laneOv[g]),
      .fullProd (laneFull[g]),
      .fracMin  (laneFracMin[g])
    );
  end

  assign fullMode = (prodMode == PM_FULL);

  always_comb begin
    if (fullMode) begin
      product = (isSat & laneFracMin[0]) ? FULL_MAX : laneFull[0];
      ovf     = {1'b0, isSat & laneFracMin[0]};
    end else begin
      product = {laneRes[1], laneRes[0]};
      ovf     = laneOv;
    end
  end

  assign operand = ctl.doSub ? ~product : product;
  always_comb begin
    if (ctl.perWord) begin
      sum[LANE_W-1:0]      = acc[LANE_W-1:0] + operand[LANE_W-1:0] + {{(LANE_W-1){1'b0}}, ctl.doSub};
      sum[DATA_W-1:LANE_W] = acc[DATA_W-1:LANE_W] + operand[DATA_W-1:LANE_W]
                             + {{(LANE_W-1){1'b0}}, ctl.doSub};
    end else begin
      sum = acc + operand + {{(DATA_W-1){1'b0}}, ctl.doSub};
    end
  end

  assign result = (ctl.doAdd | ctl.doSub) ? sum : product;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         acc <= '0;
    else if (ctl.load) acc <= result;
  end

  AST_MODULO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !isSat |-> ovf == 2'b00); // R8
  AST_FULL_UPPER_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    fullMode |-> !ovf[1]); // R4
  AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (prodMode == PM_WORD_LO && isSigned && ovf[0]) |->
      (product[LANE_W-1:0] == 32'h7FFF_FFFF || product[LANE_W-1:0] == 32'h8000_0000)); // R7
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(acc)); // R11
  AST_ACC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> acc == $past(result)); // R10
endmodule

// File: rtl/simd_mac.sv
module simd_mac
  import simd_mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        valid,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [2:0]  prodMode,
  input  logic        isSigned,
  input  logic        isSat,
  input  logic        isFrac,
  input  logic [2:0]  accMode,
  output logic [63:0] result,
  output logic [63:0] acc,
  output logic [1:0]  ovf
);
  accCtl_t ctl;

  simd_mac_ctrl u_ctrl (
    .valid   (valid),
    .accMode (accMode),
    .ctl     (ctl)
  );

  simd_mac_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .opA      (opA),
    .opB      (opB),
    .prodMode (prodMode),
    .isSigned (isSigned),
    .isSat    (isSat),
    .isFrac   (isFrac),
    .ctl      (ctl),
    .result   (result),
    .acc      (acc),
    .ovf      (ovf)
  );
endmodule

// File: tb/simd_mac_bench.sv
module simd_mac_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic valid = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [2:0] prodMode = '0, accMode = '0;
  logic isSigned = 1'b0, isSat = 1'b0, isFrac = 1'b0;
  logic [63:0] result, acc;
  logic [1:0] ovf;

  int nTests = 0;
  int nFail = 0;
  logic [63:0] accModel = '0;

  always #4 clk = ~clk;

  simd_mac u_simd_mac (
    .clk(clk), .rstN(rstN), .valid(valid), .opA(opA), .opB(opB),
    .prodMode(prodMode), .isSigned(isSigned), .isSat(isSat), .isFrac(isFrac),
    .accMode(accMode), .result(result), .acc(acc), .ovf(ovf)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mulExt(input logic [31:0] x, input logic [31:0] y,
                                         input int w, input logic s);
    logic signed [63:0] sx, sy;
    if (w == 16) begin
      sx = s ? 64'($signed(x[15:0])) : {48'b0, x[15:0]};
      sy = s ? 64'($signed(y[15:0])) : {48'b0, y[15:0]};
    end else begin
      sx = s ? 64'($signed(x)) : {32'b0, x};
      sy = s ? 64'($signed(y)) : {32'b0, y};
    end
    return sx * sy;
  endfunction

  task automatic model(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b,
                       input logic s, input logic sat, input logic fr,
                       output logic [63:0] p, output logic [1:0] ov);
    logic [63:0] pr;
    logic [31:0] x, y, v;
    logic useFrac;
    longint sp;
    p = '0; ov = '0;
    if (m == 3'd4) begin
      pr = mulExt(a[31:0], b[31:0], 32, s);
      if (s && fr && a[31:0] == 32'h8000_0000 && b[31:0] == 32'h8000_0000) begin
        p = sat ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h8000_0000_0000_0000;
        ov = {1'b0, sat};
      end else p = (s && fr) ? pr << 1 : pr;
      return;
    end
    for (int i = 0; i < 2; i++) begin
      x = a[32*i +: 32]; y = b[32*i +: 32];
      if (m == 3'd1) begin x = x >> 16; y = y >> 16; end
      useFrac = s && fr && (m != 3'd3);
      if (m == 3'd2 || m == 3'd3) pr = mulExt(x, y, 32, s);
      else pr = mulExt(x, y, 16, s);
      if (useFrac && ((m == 3'd2 && x == 32'h8000_0000 && y == 32'h8000_0000) ||
                      (m != 3'd2 && x[15:0] == 16'h8000 && y[15:0] == 16'h8000))) begin
        v = sat ? 32'h7FFF_FFFF : 32'h8000_0000;
        ov[i] = sat;
      end else begin
        if (useFrac) pr = pr << 1;
        v = (m == 3'd2) ? pr[63:32] : pr[31:0];
        if (m == 3'd3 && sat) begin
          sp = longint'(pr);
          if (s && sp > 64'sd2147483647)       begin v = 32'h7FFF_FFFF; ov[i] = 1'b1; end
          else if (s && sp < -64'sd2147483648) begin v = 32'h8000_0000; ov[i] = 1'b1; end
          else if (!s && pr[63:32] != 0)       begin v = 32'hFFFF_FFFF; ov[i] = 1'b1; end
        end
      end
      p[32*i +: 32] = v;
    end
  endtask

  function automatic logic [63:0] accComb(input logic [2:0] am, input logic [63:0] ac,
                                          input logic [63:0] p);
    case (am)
      3'd2: return ac + p;
      3'd3: return ac - p;
      3'd4: return {ac[63:32] + p[63:32], ac[31:0] + p[31:0]};
      3'd5: return {ac[63:32] - p[63:32], ac[31:0] - p[31:0]};
      default: return p;
    endcase
  endfunction

  task automatic doOp(input string tag, input logic [2:0] m, input logic [63:0] a,
                      input logic [63:0] b, input logic s, input logic sat, input logic fr,
                      input logic [2:0] am, input logic v);
    logic [63:0] p, expRes;
    logic [1:0] expOv;
    @(negedge clk);
    prodMode = m; opA = a; opB = b; isSigned = s; isSat = sat; isFrac = fr;
    accMode = am; valid = v;
    model(m, a, b, s, sat, fr, p, expOv);
    expRes = accComb(am, accModel, p);
    #1;
    chk({tag, " result"}, result, expRes);
    chk({tag, " ovf"}, {62'b0, ovf}, {62'b0, expOv});
    @(posedge clk); #1;
    if (v && am >= 3'd1 && am <= 3'd5) accModel = expRes;
    chk({tag, " acc"}, acc, accModel);
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [63:0] r;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset acc", acc, 64'h0);
    chk("R8 reset ovf", {62'b0, ovf}, 64'h0);
    rstN = 1'b1;

    // R2 halfword low/high, signed and unsigned
    doOp("R2 half-lo signed", 3'd0, 64'h0002_0007_0005_FFFE, 64'h0003_FFFF_7777_0003, 1, 0, 0, 3'd0, 1);
    chk("R2 half-lo value", result, 64'hFFFF_FFF9_FFFF_FFFA);
    doOp("R2 half-hi unsigned", 3'd1, 64'h0002_0007_0005_FFFE, 64'h0003_FFFF_7777_0003, 0, 0, 0, 3'd0, 1);
    chk("R2 half-hi value", result, 64'h0000_0006_0002_5553);
    // R3 word high/low
    doOp("R3 word-hi", 3'd2, 64'hFFFF_FFFF_0001_0000, 64'h0000_0002_0001_0000, 0, 0, 0, 3'd0, 1);
    chk("R3 word-hi value", result, 64'h0000_0001_0000_0001);
    doOp("R3 word-lo", 3'd3, 64'h0000_0010_0000_0003, 64'h0000_0010_FFFF_FFFF, 1, 0, 0, 3'd0, 1);
    chk("R3 word-lo value", result, 64'h0000_0100_FFFF_FFFD);
    // R4 full word
    doOp("R4 full unsigned", 3'd4, 64'h1234_5678_FFFF_FFFF, 64'h0000_0001_FFFF_FFFF, 0, 1, 0, 3'd0, 1);
    chk("R4 full value", result, 64'hFFFF_FFFE_0000_0001);
    doOp("R4 code7 as half-lo", 3'd7, 64'h0000_0003_0000_0004, 64'h0000_0005_0000_0006, 1, 1, 0, 3'd0, 1);
    chk("R4 code7 value", result, 64'h0000_000F_0000_0018);
    // R5 fractional
    doOp("R5 frac half", 3'd0, 64'h0000_4000_0000_C000, 64'h0000_4000_0000_4000, 1, 1, 1, 3'd0, 1);
    chk("R5 frac half value", result, 64'h2000_0000_E000_0000);
    doOp("R5 frac ignored unsigned", 3'd0, 64'h0000_8000_0000_0003, 64'h0000_8000_0000_0005, 0, 1, 1, 3'd0, 1);
    chk("R5 unsigned frac value", result, 64'h4000_0000_0000_000F);
    // R6 most-negative squared
    doOp("R6 frac min sat", 3'd1, 64'h8000_0000_8000_1234, 64'h8000_0000_8000_0001, 1, 1, 1, 3'd0, 1);
    chk("R6 sat value", result, 64'h7FFF_FFFF_7FFF_FFFF);
    chk("R6 sat flags", {62'b0, ovf}, 64'h3);
    doOp("R6 frac min wrap", 3'd1, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 1, 0, 1, 3'd0, 1);
    chk("R6 wrap value", result, 64'h8000_0000_8000_0000);
    doOp("R6 full frac min sat", 3'd4, 64'h0_8000_0000, 64'h0_8000_0000, 1, 1, 1, 3'd0, 1);
    chk("R6 full sat value", result, 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R6 full flag", {62'b0, ovf}, 64'h1);
    doOp("R6 word-hi frac min", 3'd2, 64'h8000_0000_4000_0000, 64'h8000_0000_4000_0000, 1, 1, 1, 3'd0, 1);
    chk("R6 word-hi value", result, 64'h7FFF_FFFF_2000_0000);
    // R7 word-low clamp
    doOp("R7 signed clamp", 3'd3, 64'hC000_0000_4000_0000, 64'h0000_0004_0000_0004, 1, 1, 0, 3'd0, 1);
    chk("R7 signed clamp value", result, 64'h8000_0000_7FFF_FFFF);
    chk("R7 signed flags", {62'b0, ovf}, 64'h3);
    doOp("R7 unsigned clamp", 3'd3, 64'h0000_0002_FFFF_FFFF, 64'h0000_0003_0000_0002, 0, 1, 0, 3'd0, 1);
    chk("R7 unsigned value", result, 64'h0000_0006_FFFF_FFFF);
    chk("R7 lane independence R1", {62'b0, ovf}, 64'h1);
    // R8 wrap, R9 frac ignored in word-low
    doOp("R8 wrap no flag", 3'd3, 64'h0_4000_0000, 64'h0_0000_0004, 1, 0, 0, 3'd0, 1);
    chk("R8 wrap value", result, 64'h0);
    doOp("R9 word-lo frac", 3'd3, 64'h0000_0007_0000_0003, 64'h0000_0002_0000_0005, 1, 1, 1, 3'd0, 1);
    chk("R9 integer value", result, 64'h0000_000E_0000_000F);
    // R10/R11 accumulator
    doOp("R10 write", 3'd4, 64'h0_0000_FFFF, 64'h0_0001_0001, 0, 0, 0, 3'd1, 1);
    chk("R10 write acc", acc, 64'h0000_0000_FFFF_FFFF);
    doOp("R10 add words", 3'd4, 64'h1, 64'h1, 0, 0, 0, 3'd4, 1);
    chk("R10 no carry across words", acc, 64'h0);
    doOp("R10 sub", 3'd4, 64'h1, 64'h1, 0, 0, 0, 3'd3, 1);
    chk("R10 sub acc", acc, 64'hFFFF_FFFF_FFFF_FFFF);
    doOp("R10 add", 3'd4, 64'h2, 64'h1, 0, 0, 0, 3'd2, 1);
    chk("R10 add carry", acc, 64'h1);
    doOp("R10 sub words", 3'd4, 64'h2, 64'h1, 0, 0, 0, 3'd5, 1);
    chk("R10 sub words acc", acc, 64'h0000_0000_FFFF_FFFF);
    doOp("R11 hold no valid", 3'd4, 64'h9, 64'h9, 0, 0, 0, 3'd2, 0);
    chk("R11 held", acc, 64'h0000_0000_FFFF_FFFF);
    doOp("R11 hold none mode", 3'd4, 64'h9, 64'h9, 0, 0, 0, 3'd0, 1);
    doOp("R11 hold code6", 3'd4, 64'h9, 64'h9, 0, 0, 0, 3'd6, 1);
    chk("R11 code6 held", acc, 64'h0000_0000_FFFF_FFFF);

    // random mix, R1..R11
    for (int k = 0; k < 600; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom}; rb = {$urandom, $urandom};
      if ($urandom % 8 == 0) ra[31:0] = 32'h8000_0000;
      if ($urandom % 8 == 0) rb[31:0] = 32'h8000_0000;
      if ($urandom % 8 == 0) ra[47:32] = 16'h8000;
      if ($urandom % 8 == 0) rb[47:32] = 16'h8000;
      doOp("R1 random", 3'($urandom % 5), ra, rb, 1'($urandom), 1'($urandom), 1'($urandom),
           3'($urandom % 8), 1'($urandom));
    end
    r = acc;
    chk("R11 final acc", r, accModel);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule